// File: doc/BRIEF.md
# Tagged Branch and Trap Sequencer

This block produces the next program counter for a processor whose instructions are 64 bits wide and take up two 32-bit words each. For every issued instruction it reads the format field, the control field and the 4-bit condition. It tests that condition against the N, Z, V and C flags. It then picks one next-PC source: sequential flow, a relative branch, an absolute jump, a return to a supplied return address, or a trap vector. In the same cycle it signals whether the following instruction must be squashed.

The block also handles datatype-check failures on ALU instructions. The write-back of the failing instruction is cancelled in its own cycle. The sequencer then stalls for a fixed penalty and redirects to a target relative to the PC of the failing instruction. While the penalty runs, every new request is ignored.

The PC register lives inside the block. `next_pc_o` is the value that register takes at the next rising edge. `issue_i` marks a valid instruction on `instr_i`.

Top module: `pcseq_top`

## Requirements
- R1: While `rst_n` is low, `pc_o` is the reset address (0 by default) and `stall_o` is 0.
- R2: The condition in `instr_i[52:49]` is tested against `flags_i` = {N,Z,V,C} (bit 3 = N, bit 0 = C). Each even code has the base test below, and the next odd code is its complement:
  - 0: false
  - 2: Z
  - 4: Z or (N xor V)
  - 6: N xor V
  - 8: not C or Z
  - 10: C
  - 12: N
  - 14: V
- R3: When the format `instr_i[62:60]` is 001 (branch), a true condition gives a next PC of PC plus `instr_i[14:0]` sign-extended. A false condition gives PC+2.
- R4: When the format is 010 (jump), a true condition gives a next PC of `instr_i[30:0]` with bit 31 cleared. A false condition gives PC+2.
- R5: For formats 001, 010 and 011, `instr_i[56]`=1 together with a true condition loads the next PC from `rpc_i`. This takes priority over a taken branch or jump.
- R6: For formats 001, 010 and 011, `annul_o` follows the mode in `instr_i[58:57]`:
  - 01: high when the condition is true
  - 10: high when the condition is false
  - 11: always high
  - 00: never high

  For all other formats `annul_o` is 0.
- R7: An issued instruction with `instr_i[63]`=1 sends the next PC to `trap_vec_i`. This takes priority over every other source, including a datatype failure. In that cycle `annul_o` and `wb_cancel_o` are both 0.
- R8: An issued format-000 instruction with `dt_fail_i`=1 raises `wb_cancel_o` in that cycle. `stall_o` is then high for exactly 3 cycles while the PC holds. After that, the PC becomes the failing PC plus `instr_i[14:0]` sign-extended.
- R9: While `stall_o` is high, `issue_i`, `instr_i` (including its trap bit) and `dt_fail_i` have no effect, and `annul_o` and `wb_cancel_o` stay 0.
- R10: With `issue_i` low and no stall, the PC holds and `annul_o` and `wb_cancel_o` are 0.
- R11: Formats 011 (without a return), 100, 101, 110 and 111, and format 000 without a failure, advance the PC by 2. `dt_fail_i` is ignored for every format other than 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction on `instr_i` is valid this cycle |
| instr_i | input | 64 | Current instruction |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| rpc_i | input | PC_W | Return address |
| trap_vec_i | input | PC_W | Trap vector address |
| dt_fail_i | input | 1 | Datatype check of the current instruction failed |
| pc_o | output | PC_W | Current PC |
| next_pc_o | output | PC_W | PC after the next edge |
| annul_o | output | 1 | Squash the following instruction |
| wb_cancel_o | output | 1 | Cancel write-back of the current instruction |
| stall_o | output | 1 | Datatype-trap penalty in progress |

## Verification
The bench sweeps all 16 condition codes against all 16 flag combinations. A swapped or uninverted code then shows up as a wrong branch target. It also drives a return and a taken branch together, and a trap bit together with a datatype failure. A wrong priority order would send the PC to the branch target or start a penalty instead of vectoring. During a penalty, the bench offers trap-bit instructions and further failures and counts the stall cycles. A miscounted penalty, or one that accepts new requests, would move the PC early or cancel a second write-back. Random mixes of formats, annul modes and idle cycles check annul polarity and hold behaviour against a model written in the bench.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int INSN_W   = 64;
  localparam int CC_W     = 4;
  localparam int NUM_BASE = 1 << (CC_W - 1);
  localparam int OFF_W    = 15;

  // field positions decoded by neighbouring stages
  localparam int TRAP_BIT = 63;
  localparam int FMT_LSB  = 60;
  localparam int ANN_LSB  = 57;
  localparam int RET_BIT  = 56;
  localparam int CC_LSB   = 49;

  typedef enum logic [2:0] {
    FMT_ALU_DT = 3'b000,
    FMT_BRANCH = 3'b001,
    FMT_JUMP   = 3'b010,
    FMT_LOADI  = 3'b011,
    FMT_RSV4   = 3'b100,
    FMT_CALLZ  = 3'b101,
    FMT_CALL   = 3'b110,
    FMT_RSV7   = 3'b111
  } fmt_e;

  typedef enum logic [1:0] {
    ANN_NONE     = 2'b00,
    ANN_IF_TRUE  = 2'b01,
    ANN_IF_FALSE = 2'b10,
    ANN_ALWAYS   = 2'b11
  } annul_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    fmt_e                fmt;
    logic                trap;
    logic                ctl;
    logic                ret;
    annul_e              ann;
    logic [CC_W-1:0]     cc;
    logic [OFF_W-1:0]    off;
  } dec_t;

  // even-numbered condition tests; odd codes are their complements
  function automatic logic [NUM_BASE-1:0] base_tests(flags_t f);
    logic [NUM_BASE-1:0] b;
    b    = '0;
    b[0] = 1'b0;
    b[1] = f.z;
    b[2] = f.z | (f.n ^ f.v);
    b[3] = f.n ^ f.v;
    b[4] = ~f.c | f.z;
    b[5] = f.c;
    b[6] = f.n;
    b[7] = f.v;
    return b;
  endfunction

  function automatic logic annul_eval(annul_e mode, logic hit);
    logic r;
    case (mode)
      ANN_IF_TRUE:  r = hit;
      ANN_IF_FALSE: r = ~hit;
      ANN_ALWAYS:   r = 1'b1;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
  import pcseq_pkg::*;
(
  input  logic [CC_W-1:0] code_i,
  input  flags_t          flags_i,
  output logic            hit_o
);

  logic [NUM_BASE-1:0]   base;
  logic [2*NUM_BASE-1:0] all_tests;

  always_comb base = base_tests(flags_i);

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_pair
    assign all_tests[2*g]   = base[g];
    assign all_tests[2*g+1] = ~base[g];
  end

  assign hit_o = all_tests[code_i];

endmodule

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [INSN_W-1:0] instr_i,
  output dec_t              dec_o,
  output logic [PC_W-1:0]   jtgt_o
);

  logic unused_bits;

  always_comb begin
    dec_o.fmt  = fmt_e'(instr_i[FMT_LSB +: 3]);
    dec_o.trap = instr_i[TRAP_BIT];
    dec_o.ctl  = (dec_o.fmt == FMT_BRANCH) || (dec_o.fmt == FMT_JUMP) ||
                 (dec_o.fmt == FMT_LOADI);
    dec_o.ret  = instr_i[RET_BIT];
    dec_o.ann  = annul_e'(instr_i[ANN_LSB +: 2]);
    dec_o.cc   = instr_i[CC_LSB +: CC_W];
    dec_o.off  = instr_i[OFF_W-1:0];
  end

  // absolute target: all but the top address bit come from the instruction
  assign jtgt_o      = {1'b0, instr_i[PC_W-2:0]};
  assign unused_bits = ^instr_i;

endmodule

// File: rtl/pcseq_penalty.sv
module pcseq_penalty #(
  parameter int PC_W    = 32,
  parameter int PENALTY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] tgt_i,
  output logic            busy_o,
  output logic            release_o,
  output logic [PC_W-1:0] tgt_o
);

  localparam int CNT_W = $clog2(PENALTY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(PENALTY);
      tgt_q <= tgt_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign release_o = (cnt_q == CNT_W'(1));
  assign tgt_o     = tgt_q;

  // R8: the last penalty cycle is followed by an idle sequencer
  assert_release_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !busy_o);

  // R9: a new penalty never starts while one is running
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

  // R8: a penalty only begins from a start request
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R8: the held redirect target is stable across the penalty
  assert_tgt_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> $stable(tgt_o));

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          PENALTY   = 3,
  parameter int          INSN_STEP = 2,
  parameter int unsigned RESET_PC  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [63:0]       instr_i,
  input  logic [3:0]        flags_i,
  input  logic [PC_W-1:0]   rpc_i,
  input  logic [PC_W-1:0]   trap_vec_i,
  input  logic              dt_fail_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              annul_o,
  output logic              wb_cancel_o,
  output logic              stall_o
);

  function automatic logic [PC_W-1:0] rel_target(logic [PC_W-1:0] base,
                                                 logic [OFF_W-1:0] off);
    return base + {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  dec_t            dec;
  logic [PC_W-1:0] jtgt;
  logic            cond_hit;
  logic            busy, release_now;
  logic [PC_W-1:0] held_tgt;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc, rel_pc;

  // named internal events
  logic issue_ok, trap_take, dt_trap, ret_taken, br_taken, jmp_taken;

  pcseq_decode #(.PC_W(PC_W)) u_decode (
    .instr_i (instr_i),
    .dec_o   (dec),
    .jtgt_o  (jtgt)
  );

  pcseq_cond u_cond (
    .code_i  (dec.cc),
    .flags_i (flags_t'(flags_i)),
    .hit_o   (cond_hit)
  );

  pcseq_penalty #(.PC_W(PC_W), .PENALTY(PENALTY)) u_penalty (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (dt_trap),
    .tgt_i     (rel_pc),
    .busy_o    (busy),
    .release_o (release_now),
    .tgt_o     (held_tgt)
  );

  assign seq_pc    = pc_q + PC_W'(INSN_STEP);
  assign rel_pc    = rel_target(pc_q, dec.off);

  assign issue_ok  = issue_i && !busy;
  assign trap_take = issue_ok && dec.trap;
  assign dt_trap   = issue_ok && !dec.trap && (dec.fmt == FMT_ALU_DT) && dt_fail_i;
  assign ret_taken = issue_ok && !dec.trap && dec.ctl && dec.ret && cond_hit;
  assign br_taken  = issue_ok && !dec.trap && (dec.fmt == FMT_BRANCH) && cond_hit && !ret_taken;
  assign jmp_taken = issue_ok && !dec.trap && (dec.fmt == FMT_JUMP) && cond_hit && !ret_taken;

  always_comb begin
    next_pc_o   = pc_q;
    annul_o     = 1'b0;
    wb_cancel_o = 1'b0;
    if (busy) begin
      if (release_now) next_pc_o = held_tgt;
    end else if (issue_i) begin
      if (trap_take) begin
        next_pc_o = trap_vec_i;
      end else if (dt_trap) begin
        wb_cancel_o = 1'b1;
      end else begin
        if (ret_taken)      next_pc_o = rpc_i;
        else if (br_taken)  next_pc_o = rel_pc;
        else if (jmp_taken) next_pc_o = jtgt;
        else                next_pc_o = seq_pc;
        if (dec.ctl) annul_o = annul_eval(dec.ann, cond_hit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= PC_W'(RESET_PC);
    else        pc_q <= next_pc_o;
  end

  assign pc_o    = pc_q;
  assign stall_o = busy;

  // R7: trap bit vectors the PC
  assert_trap_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !stall_o && instr_i[63]) |=> (pc_o == $past(trap_vec_i)));

  // R5: a taken return lands on the return address
  assert_ret_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_taken |=> (pc_o == $past(rpc_i)));

  // R8: a cancelled write-back is followed by the stall
  assert_wbc_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cancel_o |=> stall_o);

  // R9: nothing is annulled or cancelled during the penalty
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!annul_o && !wb_cancel_o));

  // R10: no issue, no stall: PC holds
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i && !stall_o) |=> $stable(pc_o));

  // R6: annul only for the control formats
  assert_annul_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    annul_o |-> (instr_i[62:60] inside {3'b001, 3'b010, 3'b011}));

  // R11: formats without control flow advance by one instruction
  assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !stall_o && !instr_i[63] && instr_i[62]) |=>
      (pc_o == $past(pc_o) + PC_W'(INSN_STEP)));

endmodule

// File: tb/test_pcseq_top.sv
module test_pcseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [63:0] instr_i = '0;
  logic [3:0]  flags_i = '0;
  logic [31:0] rpc_i = '0;
  logic [31:0] trap_vec_i = '0;
  logic        dt_fail_i = 1'b0;
  logic [31:0] pc_o, next_pc_o;
  logic        annul_o, wb_cancel_o, stall_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_pc = '0;
  int          m_cnt = 0;
  logic [31:0] m_tgt = '0;

  always #5 clk = ~clk;

  pcseq_top i_pcseq_top (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .flags_i(flags_i), .rpc_i(rpc_i), .trap_vec_i(trap_vec_i),
    .dt_fail_i(dt_fail_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .annul_o(annul_o), .wb_cancel_o(wb_cancel_o), .stall_o(stall_o)
  );

  function automatic logic m_cond(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (cc)
      4'd0:  return 1'b0;
      4'd1:  return 1'b1;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return z || (n != v);
      4'd5:  return !(z || (n != v));
      4'd6:  return n != v;
      4'd7:  return n == v;
      4'd8:  return !c || z;
      4'd9:  return c && !z;
      4'd10: return c;
      4'd11: return !c;
      4'd12: return n;
      4'd13: return !n;
      4'd14: return v;
      default: return !v;
    endcase
  endfunction

  function automatic logic [63:0] mk(input logic tr, input logic [2:0] fmt,
      input logic [1:0] ann, input logic ret, input logic [3:0] cc,
      input logic [30:0] lo);
    logic [63:0] w;
    w = '0;
    w[63] = tr; w[62:60] = fmt; w[58:57] = ann; w[56] = ret;
    w[52:49] = cc; w[30:0] = lo;
    return w;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic iss, input logic [63:0] ins, input logic [3:0] fl,
                     input logic [31:0] rpc, input logic [31:0] vec, input logic dtf,
                     input string force_tag);
    string tag;
    logic [31:0] e_next;
    logic e_ann, e_wbc, e_stall, c, start;
    logic [31:0] rel;
    rel = m_pc + 32'($signed(ins[14:0]));
    e_stall = (m_cnt != 0);
    e_ann = 0; e_wbc = 0; e_next = m_pc; start = 0;
    if (m_cnt != 0) begin
      tag = "R9"; if (m_cnt == 1) e_next = m_tgt;
    end else if (!iss) tag = "R10";
    else if (ins[63]) begin tag = "R7"; e_next = vec; end
    else if (ins[62:60] == 3'b000 && dtf) begin tag = "R8"; e_wbc = 1; start = 1; end
    else begin
      e_next = m_pc + 32'd2; tag = "R11";
      if (ins[62:60] inside {3'b001, 3'b010, 3'b011}) begin
        c = m_cond(ins[52:49], fl);
        e_ann = (ins[58:57] == 2'b01 && c) || (ins[58:57] == 2'b10 && !c) ||
                (ins[58:57] == 2'b11);
        if (ins[56] && c) begin tag = "R5"; e_next = rpc; end
        else if (ins[62:60] == 3'b001) begin tag = "R3"; if (c) e_next = rel; end
        else if (ins[62:60] == 3'b010) begin tag = "R4"; if (c) e_next = {1'b0, ins[30:0]}; end
      end
    end
    if (force_tag != "") tag = force_tag;
    issue_i = iss; instr_i = ins; flags_i = fl; rpc_i = rpc;
    trap_vec_i = vec; dt_fail_i = dtf;
    #1;
    chk(tag, "stall_o", 32'(stall_o), 32'(e_stall));
    chk("R6", "annul_o", 32'(annul_o), 32'(e_ann));
    chk(tag, "wb_cancel_o", 32'(wb_cancel_o), 32'(e_wbc));
    chk(tag, "next_pc_o", next_pc_o, e_next);
    @(posedge clk); #1;
    chk(tag, "pc_o", pc_o, e_next);
    if (start) begin m_cnt = 3; m_tgt = rel; end
    else if (m_cnt != 0) m_cnt--;
    m_pc = e_next;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc_o in reset", pc_o, 32'h0);
    chk("R1", "stall_o in reset", 32'(stall_o), 32'h0);
    rst_n = 1'b1;

    // R2: full condition sweep via branches of +4
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        cyc(1, mk(0, 3'b001, 2'b00, 0, 4'(cc), 31'd4), 4'(f), 0, 0, 0, "R2");

    // R3: negative offset taken branch
    cyc(1, mk(0, 3'b001, 2'b00, 0, 4'd1, 31'h7FF0), 0, 0, 0, 0, "R3");
    // R4: jump taken and not taken
    cyc(1, mk(0, 3'b010, 2'b00, 0, 4'd1, 31'h1234_5678), 0, 0, 0, 0, "R4");
    cyc(1, mk(0, 3'b010, 2'b00, 0, 4'd0, 31'h0000_0100), 0, 0, 0, 0, "R4");
    // R5: return beats a taken branch and a taken jump
    cyc(1, mk(0, 3'b001, 2'b00, 1, 4'd1, 31'd40), 0, 32'h0000_8000, 0, 0, "R5");
    cyc(1, mk(0, 3'b010, 2'b00, 1, 4'd1, 31'd40), 0, 32'h0000_9000, 0, 0, "R5");
    // R6: all annul modes with true and false conditions
    for (int a = 0; a < 4; a++) begin
      cyc(1, mk(0, 3'b011, 2'(a), 0, 4'd1, 0), 0, 0, 0, 0, "R6");
      cyc(1, mk(0, 3'b011, 2'(a), 0, 4'd0, 0), 0, 0, 0, 0, "R6");
    end
    // R7: trap bit beats a datatype failure and a taken branch
    cyc(1, mk(1, 3'b000, 2'b11, 0, 4'd1, 31'd8), 0, 0, 32'h0000_4000, 1, "R7");
    cyc(1, mk(1, 3'b001, 2'b11, 1, 4'd1, 31'd8), 0, 32'h100, 32'h0000_5000, 0, "R7");
    // R8/R9: failure, then trap bits and failures offered during penalty
    cyc(1, mk(0, 3'b000, 2'b00, 0, 4'd0, 31'h0040), 0, 0, 0, 1, "R8");
    cyc(1, mk(1, 3'b000, 2'b00, 0, 4'd0, 0), 0, 0, 32'h0000_7777, 1, "R9");
    cyc(1, mk(0, 3'b000, 2'b00, 0, 4'd0, 0), 0, 0, 0, 1, "R9");
    cyc(1, mk(0, 3'b001, 2'b11, 0, 4'd1, 31'd4), 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    // R10: idle holds
    cyc(0, mk(1, 3'b001, 2'b11, 1, 4'd1, 31'd4), 0, 0, 32'h10, 1, "R10");
    // R11: reserved and call formats ignore dt_fail
    for (int f = 3; f < 8; f++)
      cyc(1, mk(0, 3'(f), 2'b11, 0, 4'd1, 31'd4), 0, 0, 0, 1, "R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = mk($urandom_range(0, 15) == 0, 3'($urandom_range(0, 7)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             4'($urandom_range(0, 15)), 31'($urandom));
      cyc($urandom_range(0, 7) != 0, w, 4'($urandom_range(0, 15)),
          {$urandom, 1'b0} & 32'hFFFF_FFFE, {$urandom, 1'b0} & 32'hFFFF_FFFE,
          $urandom_range(0, 3) == 0, "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule